// File: doc/BRIEF.md
# SDRAM Bank State and Timing Guard

This block sits between a memory scheduler and the command pins of a four-bank SDRAM. Each clock the scheduler presents one command request: no-operation, activate, single-bank precharge, precharge of every bank, or read. Along with it come a two-bit bank number and an address field that carries either a row or a column. The guard keeps an open/idle state for every bank and a set of down-counters. From these it decides in the same cycle whether the request may go out. An accepted request is encoded onto registered RAS#, CAS#, WE#, bank and address pins. A refused request leaves `req_ready` low and the pins idle. The scheduler must hold a refused request unchanged until it is taken.

All timing limits are elaboration-time parameters counted in clock cycles. In this description, "N cycles after X" means that the command is first accepted on the N-th rising edge after the edge that accepted X. Each bank also has an overdue flag, which reports a row that has been left open for too long.

Top module: `sdram_bank_guard`

## Requirements
- R1: After reset every bank is idle, the pins show the idle encoding (RAS#, CAS# and WE# high, bank 0, address 0), every overdue flag is low, and a no-operation request sees `req_ready` high.
- R2: Request codes are 0 no-operation, 1 activate, 2 precharge one bank, 3 precharge all, and 4 read. Codes 5 to 7 act as no-operation. Pins change on the edge that accepts the command. Activate drives RAS#=0, CAS#=1, WE#=1, bank=`req_bank` and address=`req_addr`. Precharge drives RAS#=0, CAS#=1, WE#=0, bank=`req_bank` and address 0. Read drives RAS#=1, CAS#=0, WE#=1, bank=`req_bank`, with the column in address bits 7:0 and the remaining bits (including bit 10) zero.
- R3: A refused request leaves `req_ready` low and puts the idle encoding on the pins after the edge. When the request is held, it is accepted on the first edge at which its conditions are met.
- R4: A read is accepted only to an open bank, and no earlier than TRCD cycles after that bank's activate.
- R5: An activate to a bank is accepted no earlier than TRC cycles after the previous activate to the same bank.
- R6: Any two activates are at least TRRD cycles apart, even when they target different banks.
- R7: A single-bank precharge to an open bank waits until TRAS_MIN cycles after that bank's activate. A precharge to an idle bank is accepted at once.
- R8: Precharge-all closes every bank. It waits until TRAS_MIN has passed for every open bank, and it is accepted at once when all banks are idle. It drives address bit 10 high and bank 0, whatever `req_bank` holds.
- R9: `open_viol[b]` goes high TRAS_MAX cycles after bank b's activate if the bank is still open at that point. It stays high until the edge that accepts a precharge closing the bank.
- R10: An activate to a bank that is already open is refused until that bank has been precharged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | 2 | Target bank |
| req_addr | input | 11 | Row for activate, column (bits 7:0) for read |
| req_ready | output | 1 | Request is accepted at the coming edge |
| ras_n | output | 1 | Row strobe pin, active low |
| cas_n | output | 1 | Column strobe pin, active low |
| we_n | output | 1 | Write-enable pin, active low |
| ba | output | 2 | Bank select pins |
| addr | output | 11 | Address pins, bit 10 selects precharge-all |
| open_viol | output | 4 | Per-bank flag for a row left open too long |

## Verification
The overdue flag and a precharge can meet on the same edge. Two cases cover this. In the first, a bank is precharged on exactly the edge at which its TRAS_MAX count expires. In the second, a second bank opened TRRD cycles later is left alone. The first bank's flag must never rise, because the close wins that edge. The second bank's flag must rise exactly TRAS_MAX cycles after its own activate, and it must clear on the edge of the following precharge-all.

// File: rtl/sbg_pkg.sv
// Shared command codes for the SDRAM bank guard.
// Assumes the scheduler encodes requests with these values; others act as idle.
package sbg_pkg;
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_PRE  = 3'd2,
        CMD_PALL = 3'd3,
        CMD_RD   = 3'd4
    } sbg_cmd_e;
endpackage

// File: rtl/sbg_bank_timer.sv
// Per-bank state: open/idle bit plus down-counters for the read delay,
// the activate-to-activate cycle, and the minimum and maximum open time.
// Assumes every limit is at least 1 cycle. Counters reload on the activate
// edge and count down to zero, where they saturate.
module sbg_bank_timer #(
    parameter int TRCD     = 3,
    parameter int TRC      = 9,
    parameter int TRAS_MIN = 6,
    parameter int TRAS_MAX = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic close_i,
    output logic open_o,
    output logic rcd_ok_o,
    output logic rc_ok_o,
    output logic ras_ok_o,
    output logic overdue_o
);
    localparam int RCD_W = $clog2(TRCD + 1);
    localparam int RC_W  = $clog2(TRC + 1);
    localparam int MIN_W = $clog2(TRAS_MIN + 1);
    localparam int MAX_W = $clog2(TRAS_MAX + 1);

    logic             open_q;
    logic [RCD_W-1:0] rcd_q;
    logic [RC_W-1:0]  rc_q;
    logic [MIN_W-1:0] rmin_q;
    logic [MAX_W-1:0] rmax_q;

    // Track open state and run the four window counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            rcd_q  <= '0;
            rc_q   <= '0;
            rmin_q <= '0;
            rmax_q <= '0;
        end else if (act_i) begin
            open_q <= 1'b1;
            rcd_q  <= RCD_W'(TRCD - 1);
            rc_q   <= RC_W'(TRC - 1);
            rmin_q <= MIN_W'(TRAS_MIN - 1);
            rmax_q <= MAX_W'(TRAS_MAX);
        end else begin
            if (close_i) open_q <= 1'b0;
            if (rcd_q  != '0) rcd_q  <= rcd_q  - 1'b1;
            if (rc_q   != '0) rc_q   <= rc_q   - 1'b1;
            if (rmin_q != '0) rmin_q <= rmin_q - 1'b1;
            if (rmax_q != '0) rmax_q <= rmax_q - 1'b1;
        end
    end

    // Expose the window status to the command gate.
    always_comb begin
        open_o    = open_q;
        rcd_ok_o  = (rcd_q == '0);
        rc_ok_o   = (rc_q == '0);
        ras_ok_o  = (rmin_q == '0);
        overdue_o = open_q && (rmax_q == '0);
    end
endmodule

// File: rtl/sbg_rrd_timer.sv
// Shared activate spacing counter across all banks.
// Assumes TRRD >= 1; it reloads on every accepted activate.
module sbg_rrd_timer #(
    parameter int TRRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic rrd_ok_o
);
    localparam int W = $clog2(TRRD + 1);
    logic [W-1:0] cnt_q;

    // Reload on activate, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (act_i)         cnt_q <= W'(TRRD - 1);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // Another activate may go once the count is spent.
    always_comb rrd_ok_o = (cnt_q == '0);
endmodule

// File: rtl/sbg_cmd_encoder.sv
// Registers the accepted command onto the SDRAM control and address pins.
// Assumes COL_W <= AP_BIT < ROW_W; idle is driven for anything not accepted.
module sbg_cmd_encoder
    import sbg_pkg::*;
#(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sbg_cmd_e          cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  addr_i,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ROW_W-1:0]  addr_o
);
    logic              ras_d, cas_d, we_d;
    logic [BANK_W-1:0] ba_d;
    logic [ROW_W-1:0]  addr_d;

    // Map the accepted command onto the strobe levels and address bits.
    always_comb begin
        ras_d  = 1'b1;
        cas_d  = 1'b1;
        we_d   = 1'b1;
        ba_d   = '0;
        addr_d = '0;
        unique case (cmd_i)
            CMD_ACT: begin
                ras_d  = 1'b0;
                ba_d   = bank_i;
                addr_d = addr_i;
            end
            CMD_PRE: begin
                ras_d = 1'b0;
                we_d  = 1'b0;
                ba_d  = bank_i;
            end
            CMD_PALL: begin
                ras_d          = 1'b0;
                we_d           = 1'b0;
                addr_d[AP_BIT] = 1'b1;
            end
            CMD_RD: begin
                cas_d             = 1'b0;
                ba_d              = bank_i;
                addr_d[COL_W-1:0] = addr_i[COL_W-1:0];
            end
            default: ;
        endcase
    end

    // Hold the pins in registers so they change only on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n_o <= 1'b1;
            cas_n_o <= 1'b1;
            we_n_o  <= 1'b1;
            ba_o    <= '0;
            addr_o  <= '0;
        end else begin
            ras_n_o <= ras_d;
            cas_n_o <= cas_d;
            we_n_o  <= we_d;
            ba_o    <= ba_d;
            addr_o  <= addr_d;
        end
    end
endmodule

// File: rtl/sdram_bank_guard.sv
// Top of the SDRAM bank guard. Decides each cycle whether the requested
// command meets every open-state and timing rule, updates the bank timers
// on acceptance and hands the command to the pin encoder.
// Assumes the scheduler holds a refused request until req_ready is seen.
module sdram_bank_guard
    import sbg_pkg::*;
#(
    parameter int TRCD     = 3,
    parameter int TRC      = 9,
    parameter int TRRD     = 2,
    parameter int TRAS_MIN = 6,
    parameter int TRAS_MAX = 40,
    parameter int ROW_W    = 11,
    parameter int COL_W    = 8,
    parameter int AP_BIT   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       req_cmd,
    input  logic [1:0]       req_bank,
    input  logic [ROW_W-1:0] req_addr,
    output logic             req_ready,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [1:0]       ba,
    output logic [ROW_W-1:0] addr,
    output logic [3:0]       open_viol
);
    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);

    logic [NBANK-1:0] open_v, rcd_ok_v, rc_ok_v, ras_ok_v;
    logic [NBANK-1:0] act_v, close_v;
    logic             rrd_ok;
    logic             ready;
    sbg_cmd_e         cmd_acc;

    // Gate the request against the state of its bank and the shared window.
    always_comb begin
        unique case (req_cmd)
            3'(CMD_ACT):  ready = !open_v[req_bank] && rc_ok_v[req_bank] && rrd_ok;
            3'(CMD_PRE):  ready = !open_v[req_bank] || ras_ok_v[req_bank];
            3'(CMD_PALL): ready = &(~open_v | ras_ok_v);
            3'(CMD_RD):   ready = open_v[req_bank] && rcd_ok_v[req_bank];
            default:      ready = 1'b1;
        endcase
    end

    // Reduce the request to the command actually issued this edge.
    always_comb begin
        cmd_acc = CMD_NOP;
        if (ready) begin
            unique case (req_cmd)
                3'(CMD_ACT):  cmd_acc = CMD_ACT;
                3'(CMD_PRE):  cmd_acc = CMD_PRE;
                3'(CMD_PALL): cmd_acc = CMD_PALL;
                3'(CMD_RD):   cmd_acc = CMD_RD;
                default:      cmd_acc = CMD_NOP;
            endcase
        end
    end

    always_comb req_ready = ready;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            // Per-bank load and close strobes from the issued command.
            always_comb begin
                act_v[b]   = (cmd_acc == CMD_ACT) && (req_bank == BANK_W'(b));
                close_v[b] = (cmd_acc == CMD_PALL) ||
                             ((cmd_acc == CMD_PRE) && (req_bank == BANK_W'(b)));
            end

            sbg_bank_timer #(
                .TRCD(TRCD), .TRC(TRC), .TRAS_MIN(TRAS_MIN), .TRAS_MAX(TRAS_MAX)
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .act_i     (act_v[b]),
                .close_i   (close_v[b]),
                .open_o    (open_v[b]),
                .rcd_ok_o  (rcd_ok_v[b]),
                .rc_ok_o   (rc_ok_v[b]),
                .ras_ok_o  (ras_ok_v[b]),
                .overdue_o (open_viol[b])
            );
        end
    endgenerate

    sbg_rrd_timer #(.TRRD(TRRD)) u_rrd (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (cmd_acc == CMD_ACT),
        .rrd_ok_o (rrd_ok)
    );

    sbg_cmd_encoder #(
        .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)
    ) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd_acc),
        .bank_i  (req_bank),
        .addr_i  (req_addr),
        .ras_n_o (ras_n),
        .cas_n_o (cas_n),
        .we_n_o  (we_n),
        .ba_o    (ba),
        .addr_o  (addr)
    );
endmodule

// File: rtl/sbg_checker.sv
// Property checker for the SDRAM bank guard, bound to the top module.
// Assumes the default command codes from sbg_pkg.
module sbg_checker #(
    parameter int TRRD   = 2,
    parameter int ROW_W  = 11,
    parameter int AP_BIT = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       req_cmd,
    input logic [1:0]       req_bank,
    input logic [ROW_W-1:0] req_addr,
    input logic             req_ready,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [1:0]       ba,
    input logic [ROW_W-1:0] addr,
    input logic [3:0]       open_viol,
    input logic [3:0]       bank_open
);
    logic [15:0] gap_q;
    logic        act_pins;

    always_comb act_pins = !ras_n && cas_n && we_n;

    // Count cycles since the last activate seen on the pins.
    always_ff @(posedge clk) begin
        if (!rst_n)                    gap_q <= 16'(TRRD);
        else if (act_pins)             gap_q <= 16'd1;
        else if (gap_q < 16'(TRRD))    gap_q <= gap_q + 16'd1;
    end

    p_act_encode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_cmd == 3'd1) |=>
        (!ras_n && cas_n && we_n && ba == $past(req_bank) && addr == $past(req_addr)));

    p_reject_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (ras_n && cas_n && we_n));

    p_read_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_cmd == 3'd4) |-> bank_open[req_bank]);

    p_rrd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_pins |-> (gap_q >= 16'(TRRD)));

    p_pall_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_cmd == 3'd3) |=> (open_viol == 4'b0 && bank_open == 4'b0));

    p_pall_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_cmd == 3'd3) |=> (addr[AP_BIT] && ba == 2'd0 && !we_n));

    p_act_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_cmd == 3'd1) |-> !bank_open[req_bank]);
endmodule

bind sdram_bank_guard sbg_checker #(
    .TRRD(TRRD), .ROW_W(ROW_W), .AP_BIT(AP_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_cmd   (req_cmd),
    .req_bank  (req_bank),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .open_viol (open_viol),
    .bank_open (open_v)
);

// File: tb/sdram_bank_guard_test.sv
// Directed bench for the SDRAM bank guard: one task per scenario.
module sdram_bank_guard_test;
    localparam int TRCD = 3, TRC = 9, TRRD = 2, TRAS_MIN = 6, TRAS_MAX = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_cmd = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [10:0] req_addr = 11'd0;
    logic        req_ready, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [10:0] addr;
    logic [3:0]  open_viol;

    int checks = 0;
    int errors = 0;

    sdram_bank_guard #(
        .TRCD(TRCD), .TRC(TRC), .TRRD(TRRD), .TRAS_MIN(TRAS_MIN), .TRAS_MAX(TRAS_MAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_bank(req_bank),
        .req_addr(req_addr), .req_ready(req_ready), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .open_viol(open_viol)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic [10:0] a);
        req_cmd  = c;
        req_bank = b;
        req_addr = a;
    endtask

    // Hold a request until taken; compare edges refused against exp (skip if < 0).
    task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [10:0] a,
                         input int exp, input string tag);
        int n = 0;
        drive(c, b, a);
        #1;
        while (!req_ready && n < 200) begin
            step();
            #1;
            n++;
        end
        step();
        drive(3'd0, 2'd0, 11'd0);
        if (exp >= 0) chk(n == exp, tag, "edges refused", n, exp);
    endtask

    task automatic chk_pins(input logic r, input logic c, input logic w,
                            input logic [1:0] b, input logic [10:0] a, input string tag);
        chk({ras_n, cas_n, we_n, ba, addr} == {r, c, w, b, a}, tag, "pins",
            int'({ras_n, cas_n, we_n, ba, addr}), int'({r, c, w, b, a}));
    endtask

    task automatic settle();
        issue(3'd3, 2'd0, 11'd0, -1, "R8");
        repeat (TRC + 3) step();
    endtask

    task automatic t_reset();
        #1;
        chk_pins(1, 1, 1, 2'd0, 11'd0, "R1");
        chk(open_viol == 4'd0, "R1", "flags", open_viol, 0);
        chk(req_ready == 1'b1, "R1", "ready on idle", req_ready, 1);
        drive(3'd4, 2'd0, 11'h011);
        #1;
        chk(req_ready == 1'b0, "R4", "read to idle bank", req_ready, 0);
        step();
        chk_pins(1, 1, 1, 2'd0, 11'd0, "R3");
        drive(3'd0, 2'd0, 11'd0);
    endtask

    task automatic t_invalid();
        drive(3'd5, 2'd1, 11'h7FF);
        #1;
        chk(req_ready == 1'b1, "R2", "spare code ready", req_ready, 1);
        step();
        chk_pins(1, 1, 1, 2'd0, 11'd0, "R2");
        drive(3'd0, 2'd0, 11'd0);
    endtask

    task automatic t_read();
        issue(3'd1, 2'd0, 11'h5A5, 0, "R2");
        chk_pins(0, 1, 1, 2'd0, 11'h5A5, "R2");
        issue(3'd4, 2'd0, 11'h73C, TRCD - 1, "R4");
        chk_pins(1, 0, 1, 2'd0, 11'h03C, "R2");
        settle();
    endtask

    task automatic t_ras_rc();
        issue(3'd1, 2'd1, 11'h123, 0, "R5");
        issue(3'd2, 2'd1, 11'h7FF, TRAS_MIN - 1, "R7");
        chk_pins(0, 1, 0, 2'd1, 11'd0, "R7");
        issue(3'd1, 2'd1, 11'h456, TRC - TRAS_MIN - 1, "R5");
        chk_pins(0, 1, 1, 2'd1, 11'h456, "R5");
        issue(3'd2, 2'd3, 11'd0, 0, "R7");
        settle();
    endtask

    task automatic t_rrd();
        issue(3'd1, 2'd0, 11'h001, 0, "R6");
        issue(3'd1, 2'd3, 11'h002, TRRD - 1, "R6");
        chk_pins(0, 1, 1, 2'd3, 11'h002, "R6");
        settle();
    endtask

    task automatic t_open_act();
        int hits = 0;
        issue(3'd1, 2'd2, 11'h0AA, 0, "R10");
        drive(3'd1, 2'd2, 11'h0BB);
        for (int i = 0; i < TRC + 3; i++) begin
            #1;
            if (!req_ready) hits++;
            step();
        end
        chk(hits == TRC + 3, "R10", "refused while open", hits, TRC + 3);
        chk_pins(1, 1, 1, 2'd0, 11'd0, "R3");
        drive(3'd0, 2'd0, 11'd0);
        issue(3'd2, 2'd2, 11'd0, -1, "R10");
        issue(3'd1, 2'd2, 11'h0BB, 0, "R10");
        settle();
    endtask

    task automatic t_pall();
        issue(3'd1, 2'd0, 11'h010, 0, "R8");
        issue(3'd1, 2'd1, 11'h020, TRRD - 1, "R8");
        issue(3'd3, 2'd3, 11'h0FF, TRAS_MIN - 1, "R8");
        chk_pins(0, 1, 0, 2'd0, 11'h400, "R8");
        drive(3'd4, 2'd0, 11'd0);
        #1;
        chk(req_ready == 1'b0, "R8", "read after close-all", req_ready, 0);
        drive(3'd0, 2'd0, 11'd0);
        issue(3'd3, 2'd1, 11'd0, 0, "R8");
        repeat (TRC + 3) step();
    endtask

    task automatic t_overdue();
        issue(3'd1, 2'd0, 11'h100, 0, "R9");
        repeat (TRAS_MAX - 1) step();
        chk(open_viol == 4'd0, "R9", "flag one early", open_viol, 0);
        step();
        chk(open_viol == 4'b0001, "R9", "flag on time", open_viol, 1);
        issue(3'd2, 2'd0, 11'd0, 0, "R9");
        chk(open_viol == 4'd0, "R9", "flag cleared", open_viol, 0);
        repeat (TRC + 3) step();
        // Close on the expiry edge for bank 1 while bank 2 is left to expire.
        issue(3'd1, 2'd1, 11'h101, 0, "R9");
        issue(3'd1, 2'd2, 11'h102, TRRD - 1, "R9");
        repeat (TRAS_MAX - TRRD - 1) step();
        issue(3'd2, 2'd1, 11'd0, 0, "R9");
        chk(open_viol == 4'd0, "R9", "close on expiry edge", open_viol, 0);
        step();
        chk(open_viol == 4'd0, "R9", "bank2 one early", open_viol, 0);
        step();
        chk(open_viol == 4'b0100, "R9", "bank2 on time", open_viol, 4);
        issue(3'd3, 2'd0, 11'd0, 0, "R8");
        chk(open_viol == 4'd0, "R9", "cleared by close-all", open_viol, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) step();
                rst_n = 1'b1;
                t_reset();
                t_invalid();
                t_read();
                t_ras_rc();
                t_rrd();
                t_open_act();
                t_pall();
                t_overdue();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R3 watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule